// File: doc/BRIEF.md
# Memory-Mapped CSR Register Bank

This block is a small bank of 32-bit control and status registers reached by an external host over a plain synchronous bus. The bus has an address, write data, a write strobe and a read strobe. The bank holds three registers at consecutive word addresses, starting from a base address:

| Offset | Register | Host access |
|---|---|---|
| base+0 | Data register with two 10-bit fields | read/write |
| base+4 | Status register of sticky hardware flags | read-only, cleared by a host read |
| base+8 | Interrupt enable register, one bit per flag | read/write |

Every field follows its own access rule. Reserved bits are masked off on writes and read back as zero. Addresses that hit none of the three registers have no effect.

Internal hardware raises status flags by pulsing a per-flag set input. A flag stays set until the host reads the status register. The bank drives a single interrupt line, registered for one cycle. The line is high while any flag is set whose enable bit is also set.

The host bus carries no data stream, so it uses plain strobes rather than valid/ready. The host can never be stalled, and no back-pressure exists: each strobe completes in the cycle it is sampled. Read data appears on the next cycle and holds until the next read.

Top module: `csr_bank`

## Requirements
- R1: While the synchronous active-low reset is sampled low, the data fields, the status flags, the enable bits, the read data and the interrupt output are cleared to zero.
- R2: A write to base+0 stores wdata[9:0] as the first data field and wdata[19:10] as the second. A read of base+0 returns them in the same positions, with bits [31:20] always zero.
- R3: Read data reflects the addressed register one clock after a sampled read strobe. The read data is unchanged in any cycle that follows one without a read strobe.
- R4: Host writes to base+4 do not change the status flags.
- R5: A status flag is set by a one-cycle high pulse on its hardware set input (bit i of the set input drives flag i, at status bit i). The flag then stays set until a host read of base+4.
- R6: A host read of base+4 returns the flags as they stood before the read, and clears them on that same clock edge.
- R7: When a hardware set and a clearing read of base+4 coincide, the set wins for that flag.
- R8: Base+8 holds the enable bits in bits [NFLAG-1:0] and is read/write. Its upper bits are ignored on write and read as zero.
- R9: The interrupt output goes high one clock after some flag and its matching enable bit are both set. It goes low one clock after no such pair remains.
- R10: Reads of any other address, including unaligned ones inside the map, return zero. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | ADDR_W (12) | Byte address from the host |
| host_wdata | input | DW (32) | Write data from the host |
| host_wr | input | 1 | Write strobe, one access per high cycle |
| host_rd | input | 1 | Read strobe, one access per high cycle |
| host_rdata | output | DW (32) | Registered read data |
| hw_flag_set | input | NFLAG (4) | Per-flag set pulses from internal hardware |
| irq | output | 1 | Registered interrupt request |

## Verification
The decode and access rules are exercised with all-ones and mixed-bit write patterns to each mapped register. This separates stored field bits from masked reserved bits, and read/write registers from the read-only one. Reads of unmapped, unaligned and just-past-the-end addresses, followed by a read-back of the data register, show that stray accesses neither return data nor disturb state. Flag sequences check the clear-on-read behaviour: a pulse then two reads, then a set and a read in the same cycle. Together they distinguish sticky set, clear-on-read and set priority. The interrupt is probed cycle by cycle across flag arrival, enable changes and clearing reads, which tells a registered interrupt apart from a combinational or mis-gated one.

// File: rtl/csr_pkg.sv
package csr_pkg;
  // byte offsets of the mapped registers, relative to the base address
  localparam int unsigned OFF_DATA = 0;
  localparam int unsigned OFF_STAT = 4;
  localparam int unsigned OFF_IEN  = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_IEN  = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h800
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_e          sel
);
  localparam logic [ADDR_W-1:0] A_DATA = BASE_ADDR + ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR + ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_IEN  = BASE_ADDR + ADDR_W'(OFF_IEN);

  // exact compare: unaligned or out-of-map addresses fall to SEL_NONE
  always_comb begin
    if (addr == A_DATA)      sel = SEL_DATA;
    else if (addr == A_STAT) sel = SEL_STAT;
    else if (addr == A_IEN)  sel = SEL_IEN;
    else                     sel = SEL_NONE;
  end
endmodule

// File: rtl/csr_flags.sv
module csr_flags #(
  parameter int unsigned NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_pulse,
  input  logic             rd_clear,
  output logic [NFLAG-1:0] flags
);
  logic [NFLAG-1:0] flags_q;

  // sticky flags: a clearing read drops them, a same-cycle set re-raises
  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (rd_clear ? '0 : flags_q) | set_pulse;
  end

  assign flags = flags_q;
endmodule

// File: rtl/csr_irq.sv
module csr_irq #(
  parameter int unsigned NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] enables,
  output logic             irq
);
  logic             irq_q;
  logic [NFLAG-1:0] armed;

  assign armed = flags & enables;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |armed;
  end

  assign irq = irq_q;
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h800,
  parameter int unsigned DW        = 32,
  parameter int unsigned FIELD_W   = 10,
  parameter int unsigned NFIELD    = 2,
  parameter int unsigned NFLAG     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [DW-1:0]     host_rdata,
  input  logic [NFLAG-1:0]  hw_flag_set,
  output logic              irq
);
  localparam int unsigned DATA_USED = FIELD_W * NFIELD;

  csr_sel_e         sel;
  logic [DATA_USED-1:0] data_q;
  logic [NFLAG-1:0] ien_q;
  logic [NFLAG-1:0] flags;
  logic [DW-1:0]    rd_mux;
  logic [DW-1:0]    rdata_q;
  logic             wr_data, wr_ien, rd_clear;
  logic             unused_wbits;

  assign unused_wbits = ^host_wdata[DW-1:DATA_USED];

  csr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr (host_addr),
    .sel  (sel)
  );

  assign wr_data  = host_wr && (sel == SEL_DATA);
  assign wr_ien   = host_wr && (sel == SEL_IEN);
  assign rd_clear = host_rd && (sel == SEL_STAT);

  // one register per data field; reserved bits have no storage
  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)       data_q[f*FIELD_W +: FIELD_W] <= '0;
      else if (wr_data) data_q[f*FIELD_W +: FIELD_W] <= host_wdata[f*FIELD_W +: FIELD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= host_wdata[NFLAG-1:0];
  end

  csr_flags #(.NFLAG(NFLAG)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (hw_flag_set),
    .rd_clear  (rd_clear),
    .flags     (flags)
  );

  csr_irq #(.NFLAG(NFLAG)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .enables (ien_q),
    .irq     (irq)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_DATA: rd_mux[DATA_USED-1:0] = data_q;
      SEL_STAT: rd_mux[NFLAG-1:0]     = flags;
      SEL_IEN:  rd_mux[NFLAG-1:0]     = ien_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (host_rd) rdata_q <= rd_mux;
  end

  assign host_rdata = rdata_q;
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk
  import csr_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned DATA_USED = 20,
  parameter int unsigned NFLAG     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             host_rd,
  input csr_sel_e         sel,
  input logic [NFLAG-1:0] hw_flag_set,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] ien_q,
  input logic [DW-1:0]    host_rdata,
  input logic             irq
);
  // R1: reset clears state
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (flags == '0 && ien_q == '0 && !irq && host_rdata == '0));

  // R2: reserved upper bits never read back
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[DW-1:DATA_USED] == '0);

  // R3: read data holds without a read strobe
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

  // R4: host write to status has no effect on flags
  p_status_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && sel == SEL_STAT && hw_flag_set == '0 && !host_rd) |=> flags == $past(flags));

  // R5: flags are sticky without a clearing read
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && sel == SEL_STAT) |=> (flags & $past(flags)) == $past(flags));

  // R6: clearing read empties flags when nothing sets
  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && sel == SEL_STAT && hw_flag_set == '0) |=> flags == '0);

  // R7: a set pulse always lands, even against a clearing read
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_flag_set != '0) |=> (flags & $past(hw_flag_set)) == $past(hw_flag_set));

  // R9: interrupt only follows a set flag and a set enable
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(flags) != '0 && $past(ien_q) != '0));

  // R10: unmapped reads return zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && sel == SEL_NONE) |=> host_rdata == '0);
endmodule

bind csr_bank csr_bank_chk #(
  .DW(DW), .DATA_USED(DATA_USED), .NFLAG(NFLAG)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .sel         (sel),
  .hw_flag_set (hw_flag_set),
  .flags       (flags),
  .ien_q       (ien_q),
  .host_rdata  (host_rdata),
  .irq         (irq)
);

// File: tb/tb_csr_bank.sv
module tb_csr_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_HW = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{OP_WR, 12'h800, 32'hFFFF_FFFF, 32'h0, 4'd2},
    '{OP_RD, 12'h800, 32'h0, 32'h000F_FFFF, 4'd2},   // R2 all ones masked
    '{OP_WR, 12'h800, 32'h1234_5678, 32'h0, 4'd2},
    '{OP_RD, 12'h800, 32'h0, 32'h0004_5678, 4'd2},   // R2 mixed bits
    '{OP_WR, 12'h804, 32'h0000_000F, 32'h0, 4'd4},
    '{OP_RD, 12'h804, 32'h0, 32'h0000_0000, 4'd4},   // R4 write ignored
    '{OP_HW, 12'h000, 32'h0000_0005, 32'h0, 4'd5},
    '{OP_RD, 12'h804, 32'h0, 32'h0000_0005, 4'd5},   // R5 sticky, R6 read value
    '{OP_RD, 12'h804, 32'h0, 32'h0000_0000, 4'd6},   // R6 cleared
    '{OP_WR, 12'h808, 32'hFFFF_FFFF, 32'h0, 4'd8},
    '{OP_RD, 12'h808, 32'h0, 32'h0000_000F, 4'd8},   // R8 upper bits zero
    '{OP_WR, 12'h900, 32'h0000_ABCD, 32'h0, 4'd10},
    '{OP_RD, 12'h900, 32'h0, 32'h0000_0000, 4'd10},  // R10 unmapped read
    '{OP_RD, 12'h802, 32'h0, 32'h0000_0000, 4'd10},  // R10 unaligned
    '{OP_WR, 12'h80C, 32'h0000_0001, 32'h0, 4'd10},
    '{OP_RD, 12'h80C, 32'h0, 32'h0000_0000, 4'd10},  // R10 just past the map
    '{OP_RD, 12'h800, 32'h0, 32'h0004_5678, 4'd10}   // R10 stray writes ignored
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [31:0] host_rdata;
  logic [3:0]  hw_flag_set = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_bank dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .hw_flag_set(hw_flag_set), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic hw_pulse(input logic [3:0] f);
    @(negedge clk);
    hw_flag_set = f;
    @(negedge clk);
    hw_flag_set = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired (all requirements) got=hung exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 rdata in reset", host_rdata, 32'h0);
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    bus_read(12'h800, rd); chk("R1 data after reset", rd, 32'h0);
    bus_read(12'h804, rd); chk("R1 status after reset", rd, 32'h0);
    bus_read(12'h808, rd); chk("R1 enables after reset", rd, 32'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].op)
        OP_WR: bus_write(VECS[i].addr, VECS[i].data);
        OP_HW: hw_pulse(VECS[i].data[3:0]);
        default: begin
          bus_read(VECS[i].addr, rd);
          chk($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
        end
      endcase
    end

    // R9: irq timing with enables all set (0xF)
    hw_pulse(4'h2);
    chk("R9 irq not yet high", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq high one clock later", {31'h0, irq}, 32'h1);
    bus_read(12'h804, rd);
    chk("R6 status read value", rd, 32'h2);
    chk("R9 irq still high at read edge", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq drops after clear", {31'h0, irq}, 32'h0);

    // R8/R9: enable gating
    bus_write(12'h808, 32'h1);
    hw_pulse(4'h4);
    repeat (2) @(negedge clk);
    chk("R9 masked flag gives no irq", {31'h0, irq}, 32'h0);
    bus_write(12'h808, 32'h4);
    chk("R9 irq waits one clock after enable", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq after enable", {31'h0, irq}, 32'h1);
    bus_read(12'h804, rd);
    chk("R5 masked flag still sticky", rd, 32'h4);
    bus_write(12'h808, 32'hF);

    // R7: set and clearing read in the same cycle
    hw_pulse(4'h1);
    @(negedge clk);
    host_addr = 12'h804; host_rd = 1'b1; hw_flag_set = 4'h2;
    @(negedge clk);
    host_rd = 1'b0; hw_flag_set = '0;
    chk("R7 read returns pre-set flags", host_rdata, 32'h1);
    bus_read(12'h804, rd); chk("R7 set survived clear", rd, 32'h2);
    bus_read(12'h804, rd); chk("R6 cleared after second read", rd, 32'h0);

    // R3: latency and hold
    bus_read(12'h800, rd);
    @(negedge clk);
    host_addr = 12'h808; host_rd = 1'b1;
    #1;
    chk("R3 no combinational read path", host_rdata, 32'h0004_5678);
    @(negedge clk);
    host_rd = 1'b0;
    chk("R3 data one clock after strobe", host_rdata, 32'hF);
    host_addr = 12'h800;
    repeat (3) @(negedge clk);
    chk("R3 data holds without strobe", host_rdata, 32'hF);

    // R1: reset mid-run
    hw_pulse(4'h8);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 irq cleared by reset", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    bus_read(12'h800, rd); chk("R1 data cleared by reset", rd, 32'h0);
    bus_read(12'h804, rd); chk("R1 flags cleared by reset", rd, 32'h0);
    bus_read(12'h808, rd); chk("R1 enables cleared by reset", rd, 32'h0);

    finish_run();
  end
endmodule